// File: doc/BRIEF.md
# Write-Training Burst Buffer

This block is the memory-side store used while the host trains its write-data path. The host streams write bursts of 16 beats into it. Each beat carries one data byte and one side bit. A read command later plays the stored bursts back, oldest first, on a beat-wide output. No activate, precharge or refresh sequencing is involved. A burst is written and read back with one command each.

A mode input selects the source of the side bit. In the default setting it is the data-mask/inversion pin, so the data byte and the mask bit travel together. In the strobe-parity setting the parity pin is captured instead, and the mask input is ignored. On read-back the captured parity is presented on the mask output. The two sources are never stored at the same time, so a system that uses both pins needs two training passes. Switching the mode empties the buffer.

Top module: `wtf_train_fifo`

## Requirements
- R1: After reset `rd_valid_o`, `rd_dq_o`, `rd_mask_o`, `ovf_o` and `udf_o` are all 0.
- R2: Sixteen sampled beats with `wr_beat_i` high form one burst, and beat k of a burst is the k-th sampled beat. A read command sampled while idle gives 16 consecutive cycles of `rd_valid_o`, starting the cycle after the command, with beat 0 first. Bursts come back in the order they were written.
- R3: With `par_mode_i` = 0 the stored side bit is `wr_mask_i` and `wr_par_i` has no effect on what is returned on `rd_mask_o`.
- R4: With `par_mode_i` = 1 the stored side bit is `wr_par_i`, returned on `rd_mask_o`, and `wr_mask_i` has no effect.
- R5: The buffer holds 8 complete bursts, and writing 8 bursts into an empty buffer raises no overflow.
- R6: Completing a burst while 8 are held, without a read in the same cycle, discards the oldest burst and sets `ovf_o`. `ovf_o` stays set until the mode changes or reset.
- R7: A read command with no burst stored returns 16 valid beats of all zeros and sets `udf_o`. `udf_o` stays set until the mode changes or reset.
- R8: A change of `par_mode_i` empties the buffer, discards a partly received burst, stops a read in progress, and clears `ovf_o` and `udf_o`. Write beats and read commands in the cycle of the change are dropped.
- R9: A read command sampled while a read burst is still being output is ignored.
- R10: While `rd_valid_o` is 0, `rd_dq_o` and `rd_mask_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode_i | input | 1 | Side-bit source: 0 mask pin, 1 strobe-parity pin |
| wr_beat_i | input | 1 | Write beat present this cycle |
| wr_dq_i | input | 8 | Write data byte |
| wr_mask_i | input | 1 | Write mask/inversion bit |
| wr_par_i | input | 1 | Write strobe-parity bit |
| rd_cmd_i | input | 1 | Read-burst command |
| rd_valid_o | output | 1 | Read beat present |
| rd_dq_o | output | 8 | Read data byte |
| rd_mask_o | output | 1 | Read side bit (mask or captured parity) |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
The assertions check on every cycle that a read run never lasts longer than one burst, that a run starts only after a command, and that the outputs are quiet when no beat is valid. They also check that both flags stay set while the mode is steady and drop after a mode change. Only the bench scenarios can show that the data returned is the right data. These cover beat order, burst order across pointer wrap, which pin fed the side bit, which burst an overflow discarded, and that a partial burst is dropped at a mode change.

// File: rtl/wtf_pkg.sv
package wtf_pkg;
  typedef enum logic {
    SRC_MASK   = 1'b0,
    SRC_PARITY = 1'b1
  } cap_src_e;
endpackage

// File: rtl/wtf_rst_sync.sv
module wtf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/wtf_wr_assemble.sv
module wtf_wr_assemble #(
  parameter int DQ_W  = 8,
  parameter int BEATS = 16,
  localparam int BEAT_W  = DQ_W + 1,
  localparam int BURST_W = BEATS * BEAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               beat_en_i,
  input  logic [DQ_W-1:0]    dq_i,
  input  logic               side_i,
  output logic               commit_o,
  output logic [BURST_W-1:0] word_o
);
  localparam int BC_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [BC_W-1:0]    bcnt_q, bcnt_d;
  logic [BURST_W-1:0] asm_q, asm_d;
  logic               asm_en;

  always_comb begin
    asm_d    = asm_q;
    bcnt_d   = bcnt_q;
    commit_o = 1'b0;
    if (flush_i) begin
      bcnt_d = '0;
    end else if (beat_en_i) begin
      asm_d[int'(bcnt_q)*BEAT_W +: BEAT_W] = {side_i, dq_i};
      if (bcnt_q == BC_W'(BEATS - 1)) begin
        bcnt_d   = '0;
        commit_o = 1'b1;
      end else begin
        bcnt_d = bcnt_q + 1'b1;
      end
    end
  end

  assign word_o = asm_d;
  assign asm_en = beat_en_i && !flush_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt_q <= '0;
    else        bcnt_q <= bcnt_d;
  end

  always_ff @(posedge clk) begin
    if (asm_en) asm_q <= asm_d;
  end
endmodule

// File: rtl/wtf_ptr_ctrl.sv
module wtf_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_req_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             pop_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d, udf_q, udf_d;
  logic             pop, under, drop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    udf_d = udf_q;
    pop   = pop_req_i && (cnt_q != '0);
    under = pop_req_i && (cnt_q == '0);
    drop  = push_i && (cnt_q == CNT_W'(DEPTH)) && !pop;
    if (flush_i) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
      udf_d = 1'b0;
    end else begin
      if (push_i)       wr_d = ptr_next(wr_q);
      if (pop || drop)  rd_d = ptr_next(rd_q);
      if (push_i && !pop && !drop) cnt_d = cnt_q + 1'b1;
      else if (pop && !push_i)     cnt_d = cnt_q - 1'b1;
      if (drop)  ovf_d = 1'b1;
      if (under) udf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign rd_ptr_o = rd_q;
  assign wr_ptr_o = wr_q;
  assign pop_o    = pop && !flush_i;
  assign ovf_o    = ovf_q;
  assign udf_o    = udf_q;
endmodule

// File: rtl/wtf_rd_serial.sv
module wtf_rd_serial #(
  parameter int DQ_W  = 8,
  parameter int BEATS = 16,
  localparam int BEAT_W  = DQ_W + 1,
  localparam int BURST_W = BEATS * BEAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               load_i,
  input  logic [BURST_W-1:0] word_i,
  output logic               busy_o,
  output logic [DQ_W-1:0]    dq_o,
  output logic               side_o
);
  localparam int RC_W = $clog2(BEATS + 1);

  logic [BURST_W-1:0] sh_q, sh_d;
  logic [RC_W-1:0]    left_q, left_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (flush_i) begin
      sh_d   = '0;
      left_d = '0;
    end else if (load_i) begin
      sh_d   = word_i;
      left_d = RC_W'(BEATS);
    end else if (left_q != '0) begin
      sh_d   = sh_q >> BEAT_W;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign busy_o = (left_q != '0);
  assign dq_o   = sh_q[DQ_W-1:0];
  assign side_o = sh_q[DQ_W];
endmodule

// File: rtl/wtf_train_fifo.sv
module wtf_train_fifo
  import wtf_pkg::*;
#(
  parameter int DQ_W  = 8,
  parameter int BEATS = 16,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            par_mode_i,
  input  logic            wr_beat_i,
  input  logic [DQ_W-1:0] wr_dq_i,
  input  logic            wr_mask_i,
  input  logic            wr_par_i,
  input  logic            rd_cmd_i,
  output logic            rd_valid_o,
  output logic [DQ_W-1:0] rd_dq_o,
  output logic            rd_mask_o,
  output logic            ovf_o,
  output logic            udf_o
);
  localparam int BEAT_W  = DQ_W + 1;
  localparam int BURST_W = BEATS * BEAT_W;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic               rst_int_n;
  cap_src_e           mode_q, mode_d;
  logic               flush;
  logic               side_bit;
  logic               beat_en;
  logic               commit;
  logic [BURST_W-1:0] commit_word;
  logic               busy;
  logic               pop_req;
  logic               pop;
  logic [PTR_W-1:0]   rd_ptr, wr_ptr;
  logic [BURST_W-1:0] load_word;
  logic [BURST_W-1:0] mem_q [DEPTH];

  wtf_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Capture source and flush on any source change.
  assign mode_d   = cap_src_e'(par_mode_i);
  assign flush    = (mode_d != mode_q);
  assign side_bit = (mode_q == SRC_PARITY) ? wr_par_i : wr_mask_i;
  assign beat_en  = wr_beat_i && !flush;
  assign pop_req  = rd_cmd_i && !busy && !flush;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= SRC_MASK;
    else            mode_q <= mode_d;
  end

  wtf_wr_assemble #(.DQ_W(DQ_W), .BEATS(BEATS)) i_wr_assemble (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush_i   (flush),
    .beat_en_i (beat_en),
    .dq_i      (wr_dq_i),
    .side_i    (side_bit),
    .commit_o  (commit),
    .word_o    (commit_word)
  );

  wtf_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush_i   (flush),
    .push_i    (commit),
    .pop_req_i (pop_req),
    .rd_ptr_o  (rd_ptr),
    .wr_ptr_o  (wr_ptr),
    .pop_o     (pop),
    .ovf_o     (ovf_o),
    .udf_o     (udf_o)
  );

  // Burst storage: one word per complete burst.
  always_ff @(posedge clk) begin
    if (commit) mem_q[wr_ptr] <= commit_word;
  end

  assign load_word = pop ? mem_q[rd_ptr] : '0;

  wtf_rd_serial #(.DQ_W(DQ_W), .BEATS(BEATS)) i_rd_serial (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .flush_i (flush),
    .load_i  (pop_req),
    .word_i  (load_word),
    .busy_o  (busy),
    .dq_o    (rd_dq_o),
    .side_o  (rd_mask_o)
  );

  assign rd_valid_o = busy;
endmodule

// File: rtl/wtf_train_fifo_chk.sv
module wtf_train_fifo_chk #(
  parameter int DQ_W  = 8,
  parameter int BEATS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            par_mode_i,
  input logic            rd_cmd_i,
  input logic            rd_valid_o,
  input logic [DQ_W-1:0] rd_dq_o,
  input logic            rd_mask_o,
  input logic            ovf_o,
  input logic            udf_o
);
  localparam int RUN_W = $clog2(BEATS + 2) + 1;

  logic [RUN_W-1:0] run_q;
  logic [1:0]       arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (rd_valid_o) run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
    else                 run_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              arm_q <= 2'd0;
    else if (arm_q != 2'd3)  arm_q <= arm_q + 2'd1;
  end

  // R2: a read run never exceeds one burst
  p_run_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(BEATS));

  // R2: a read run begins only after a command
  p_start_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid_o) |-> $past(rd_cmd_i));

  // R10: outputs quiet between bursts
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> (rd_dq_o == '0) && !rd_mask_o);

  // R6: overflow flag holds while the mode is steady
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && $stable(par_mode_i) |=> ovf_o);

  // R7: underflow flag holds while the mode is steady
  p_udf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    udf_o && $stable(par_mode_i) |=> udf_o);

  // R8: a mode change clears both flags
  p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q == 2'd3) && (par_mode_i != $past(par_mode_i)) |=> !ovf_o && !udf_o);
endmodule

bind wtf_train_fifo wtf_train_fifo_chk #(.DQ_W(DQ_W), .BEATS(BEATS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .par_mode_i (par_mode_i),
  .rd_cmd_i   (rd_cmd_i),
  .rd_valid_o (rd_valid_o),
  .rd_dq_o    (rd_dq_o),
  .rd_mask_o  (rd_mask_o),
  .ovf_o      (ovf_o),
  .udf_o      (udf_o)
);

// File: tb/test_wtf_train_fifo.sv
module test_wtf_train_fifo;
  localparam int DQ_W  = 8;
  localparam int BEATS = 16;
  localparam int DEPTH = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            par_mode = 1'b0;
  logic            wr_beat = 1'b0;
  logic [DQ_W-1:0] wr_dq = '0;
  logic            wr_mask = 1'b0;
  logic            wr_par = 1'b0;
  logic            rd_cmd = 1'b0;
  logic            rd_valid;
  logic [DQ_W-1:0] rd_dq;
  logic            rd_mask;
  logic            ovf, udf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wtf_train_fifo #(.DQ_W(DQ_W), .BEATS(BEATS), .DEPTH(DEPTH)) i_wtf_train_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_mode_i (par_mode),
    .wr_beat_i  (wr_beat),
    .wr_dq_i    (wr_dq),
    .wr_mask_i  (wr_mask),
    .wr_par_i   (wr_par),
    .rd_cmd_i   (rd_cmd),
    .rd_valid_o (rd_valid),
    .rd_dq_o    (rd_dq),
    .rd_mask_o  (rd_mask),
    .ovf_o      (ovf),
    .udf_o      (udf)
  );

  function automatic logic [DQ_W-1:0] e_dq(int s, int i);
    return DQ_W'((s * 37 + i * 11 + 5) & 8'hFF);
  endfunction
  function automatic logic e_mk(int s, int i);
    return 1'((s + i) & 1);
  endfunction
  function automatic logic e_pr(int s, int i);
    return 1'(((s * 3 + i) >> 1) & 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_burst(int s);
    for (int i = 0; i < BEATS; i++) begin
      @(negedge clk);
      wr_beat = 1'b1;
      wr_dq   = e_dq(s, i);
      wr_mask = e_mk(s, i);
      wr_par  = e_pr(s, i);
    end
    @(negedge clk);
    wr_beat = 1'b0;
    wr_dq   = '0;
    wr_mask = 1'b0;
    wr_par  = 1'b0;
  endtask

  // Reads one burst; zero selects the all-zero expectation, poke is the beat
  // after which a second command is pulsed (-1 for none).
  task automatic get_burst(int s, bit zero, bit pm, int poke, string req);
    int bad = 0;
    int act = 0;
    int exp = 0;
    logic [DQ_W-1:0] xd;
    logic xm;
    @(negedge clk);
    rd_cmd = 1'b1;
    @(negedge clk);
    rd_cmd = 1'b0;
    for (int i = 0; i < BEATS; i++) begin
      if (i > 0) @(negedge clk);
      xd = zero ? '0 : e_dq(s, i);
      xm = zero ? 1'b0 : (pm ? e_pr(s, i) : e_mk(s, i));
      if (!rd_valid || rd_dq !== xd || rd_mask !== xm) begin
        if (bad == 0) begin
          act = {i, 3'b000, rd_valid, rd_mask, rd_dq};
          exp = {i, 3'b000, 1'b1, xm, xd};
        end
        bad++;
      end
      rd_cmd = (i == poke);
    end
    @(negedge clk);
    rd_cmd = 1'b0;
    if (rd_valid) begin
      if (bad == 0) begin
        act = 32'h100;
        exp = 32'h0;
      end
      bad++;
    end
    chk(bad == 0, req, $sformatf("burst seed %0d", s), act, exp);
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    par_mode = m;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!rd_valid, "R1", "rd_valid", int'(rd_valid), 0);
    chk(rd_dq == '0 && !rd_mask, "R1", "read outputs", int'({rd_mask, rd_dq}), 0);
    chk(!ovf && !udf, "R1", "flags", int'({ovf, udf}), 0);

    // R2 R3 R5: write n bursts then read them back, n swept 1..DEPTH
    for (int n = 1; n <= DEPTH; n++) begin
      for (int k = 0; k < n; k++) put_burst(n * 10 + k);
      for (int k = 0; k < n; k++) get_burst(n * 10 + k, 1'b0, 1'b0, -1, "R2/R3");
      chk(!ovf, "R5", $sformatf("no overflow at %0d bursts", n), int'(ovf), 0);
    end
    // R10 quiet while idle
    chk(!rd_valid && rd_dq == '0 && !rd_mask, "R10", "idle outputs",
        int'({rd_valid, rd_mask, rd_dq}), 0);

    // R7 empty read
    get_burst(0, 1'b1, 1'b0, -1, "R7");
    chk(udf, "R7", "underflow flag", int'(udf), 1);
    repeat (3) @(negedge clk);
    chk(udf, "R7", "underflow flag sticky", int'(udf), 1);

    // R8 mode change clears flags; R4 parity capture
    set_mode(1'b1);
    chk(!udf && !ovf, "R8", "flags after mode change", int'({ovf, udf}), 0);
    for (int k = 0; k < 3; k++) put_burst(50 + k);
    for (int k = 0; k < 3; k++) get_burst(50 + k, 1'b0, 1'b1, -1, "R4");

    // R6 overflow: ten bursts into eight slots
    for (int k = 0; k < DEPTH + 2; k++) put_burst(100 + k);
    chk(ovf, "R6", "overflow flag", int'(ovf), 1);
    for (int k = 2; k < DEPTH + 2; k++) get_burst(100 + k, 1'b0, 1'b1, -1, "R6");
    chk(ovf, "R6", "overflow flag sticky", int'(ovf), 1);
    get_burst(0, 1'b1, 1'b1, -1, "R6");

    // R8 flush of stored bursts and a partial burst
    put_burst(150);
    put_burst(151);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      wr_beat = 1'b1;
      wr_dq   = 8'hA5;
      wr_mask = 1'b1;
      wr_par  = 1'b1;
    end
    @(negedge clk);
    wr_beat = 1'b0;
    set_mode(1'b0);
    chk(!ovf && !udf, "R8", "flags cleared", int'({ovf, udf}), 0);
    get_burst(0, 1'b1, 1'b0, -1, "R8");
    put_burst(200);
    get_burst(200, 1'b0, 1'b0, -1, "R8");

    // R9 command while busy ignored
    put_burst(210);
    put_burst(211);
    get_burst(210, 1'b0, 1'b0, 5, "R9");
    get_burst(211, 1'b0, 1'b0, BEATS - 1, "R9");
    get_burst(0, 1'b1, 1'b0, -1, "R9");

    // R8 mode change aborts an in-flight read
    put_burst(220);
    @(negedge clk);
    rd_cmd = 1'b1;
    @(negedge clk);
    rd_cmd = 1'b0;
    repeat (3) @(negedge clk);
    par_mode = 1'b1;
    @(negedge clk);
    chk(!rd_valid && rd_dq == '0 && !rd_mask, "R8", "read aborted",
        int'({rd_valid, rd_mask, rd_dq}), 0);
    chk(!udf && !ovf, "R8", "flags after abort", int'({ovf, udf}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule